// File: doc/BRIEF.md
# Cartridge Bring-Up and Header Fetch Sequencer

This block is the host-side controller that brings a removable memory cartridge out of reset and loads its identity and its 4 KB header into a local buffer. One start pulse runs the whole sequence. The block first lets the cartridge leave reset and waits a long settling time. It then reads the 4-byte chip identifier and repeats that read until the cartridge returns a nonzero value. After a further settle interval it streams the header into the buffer.

The cartridge side is reached through a command port and a byte receive port. The command port presents an 8-byte command together with the number of data bytes it requests. The receive port delivers one byte per valid cycle. The header can arrive in one of two ways. Some cartridges need it as eight 512-byte pieces. That choice is made from a cartridge-type input and from the most significant bit of the chip identifier. All other cartridges return it in a single 4096-byte read. Cartridges that never return a nonzero identifier are reported through an error flag once a bounded number of attempts has been used up.

Top module: `cart_boot_seq`

## Requirements
- R1: After reset `cart_rst_n_o` is 0 and `busy_o`, `done_o`, `error_o`, `cmd_valid_o`, `hdr_we_o` and `chip_id_o` are all 0.
- R2: The edge that accepts `start_i` in idle sets `cart_rst_n_o` to 1. The first command appears on `cmd_valid_o` exactly BOOT_WAIT_CYC cycles after that edge. No command is ever presented while `cart_rst_n_o` is 0.
- R3: An identifier read is the byte 90h in `cmd_bytes_o[63:56]` (the first byte sent), followed by seven zero bytes, with `cmd_len_o` = 4.
- R4: The four identifier bytes are assembled with the first received byte in bits 7:0. A value of zero causes the identifier read to be reissued. A nonzero value is placed on `chip_id_o`, which is cleared on each accepted start.
- R5: If fewer than four identifier bytes have arrived POLL_TIMEOUT_CYC cycles after the command was accepted, the attempt counts as failed and the read is reissued.
- R6: After MAX_POLLS failed attempts the block sets `error_o`, drops `busy_o`, returns `cart_rst_n_o` to 0 and issues no header read.
- R7: The first header command appears exactly SETTLE_CYC cycles after the edge that accepted the last byte of the nonzero identifier.
- R8: A header command is opcode 00h in bits 63:56, then a 32-bit byte address sent most significant byte first in bits 55:24, then zeros in bits 23:0.
- R9: If `ext_type_i` (sampled at start) is 1 and chip ID bit 31 is 1, the header is fetched as eight commands of length 512 at addresses 0, 200h, ..., E00h in ascending order. Otherwise it is fetched as one command of length 4096 at address 0.
- R10: Every header byte received is written through `hdr_we_o` at consecutive buffer addresses 0 to 4095, carrying the received value.
- R11: `done_o` rises on the edge that writes buffer address 4095, with `busy_o` low. It stays high until the next accepted start clears it.
- R12: `start_i` has no effect while `busy_o` is high.
- R13: A presented command keeps `cmd_valid_o`, `cmd_bytes_o` and `cmd_len_o` stable until a cycle with `cmd_ready_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| ext_type_i | input | 1 | Cartridge is of the extended type (sampled at start) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Header fully loaded |
| error_o | output | 1 | Identifier never became valid |
| cart_rst_n_o | output | 1 | Reset to the cartridge, active low |
| cmd_valid_o | output | 1 | Command presented |
| cmd_ready_i | input | 1 | Command taken by the bus side |
| cmd_bytes_o | output | 64 | Command, first byte in bits 63:56 |
| cmd_len_o | output | $clog2(HDR_BYTES)+1 | Data bytes requested |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| hdr_we_o | output | 1 | Header buffer write strobe |
| hdr_addr_o | output | $clog2(HDR_BYTES) | Header buffer byte address |
| hdr_data_o | output | 8 | Header buffer write data |
| chip_id_o | output | 8*ID_BYTES | Captured chip identifier |

## Verification
The bench covers several corner cases. It mixes zero replies with silent attempts that must time out, and it runs with exactly MAX_POLLS-1 failures as well as MAX_POLLS failures. A retry counter that is off by one would either give up on a cartridge that was still usable or issue one attempt too many. It covers all four combinations of the type flag and identifier bit 31. A wrong strategy choice shows up as the wrong command count, and a wrong chunk address shows up as corrupted buffer bytes, because the data the bench model returns depends on the requested address. It measures the boot and settle delays to the exact cycle. It also fires start pulses in the middle of the boot wait and in the middle of the header stream. A design that restarted on those pulses would shift the first command or write more than 4096 bytes.

// File: rtl/cbs_pkg.sv
// Shared types and constants of the cartridge bring-up sequencer.
// Assumes an 8-byte command whose first byte is the opcode.
package cbs_pkg;

    localparam logic [7:0] OP_CHIP_ID = 8'h90;
    localparam logic [7:0] OP_READ    = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOOT,
        ST_ID_CMD,
        ST_ID_RX,
        ST_SETTLE,
        ST_HDR_CMD,
        ST_HDR_RX
    } seq_state_t;

    typedef enum logic {
        CMD_ID,
        CMD_HDR
    } cmd_kind_t;

endpackage

// File: rtl/cbs_timer.sv
// Loadable down-counter used for every wait of the sequencer.
// A load sets the count; otherwise it decrements to zero and stays there.
// zero_o is high whenever the count is zero.
module cbs_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Count register: load has priority, then decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cbs_cmd_fmt.sv
// Combinational command formatter. Produces the 8-byte command word
// (first byte in the top bits) and the requested data length for either
// an identifier read or a header read. Assumes addresses fit in 32 bits.
module cbs_cmd_fmt
    import cbs_pkg::*;
#(
    parameter int ID_BYTES    = 4,
    parameter int HDR_BYTES   = 4096,
    parameter int CHUNK_BYTES = 512,
    parameter int LEN_W       = 13
) (
    input  cmd_kind_t        kind_i,
    input  logic             chunked_i,
    input  logic [31:0]      addr_i,
    output logic [63:0]      bytes_o,
    output logic [LEN_W-1:0] len_o
);

    // Select opcode, address field and length for the command kind.
    always_comb begin
        if (kind_i == CMD_ID) begin
            bytes_o = {OP_CHIP_ID, 56'h0};
            len_o   = LEN_W'(ID_BYTES);
        end else begin
            bytes_o = {OP_READ, addr_i, 24'h0};
            len_o   = chunked_i ? LEN_W'(CHUNK_BYTES) : LEN_W'(HDR_BYTES);
        end
    end

endmodule

// File: rtl/cbs_id_capture.sv
// Assembles the chip identifier from the receive stream, first byte in
// the lowest lane. The last lane is taken straight from the bus, so the
// full word is available in the cycle the final byte arrives (last_o).
// Assumes ID_BYTES >= 2 and that the caller leaves capture after last_o.
module cbs_id_capture #(
    parameter int ID_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  en_i,
    input  logic                  rx_valid_i,
    input  logic [7:0]            rx_data_i,
    output logic                  last_o,
    output logic [8*ID_BYTES-1:0] full_o
);

    localparam int IW = $clog2(ID_BYTES);

    logic          take;
    logic [IW-1:0] idx_q;

    assign take   = en_i && rx_valid_i;
    assign last_o = take && (idx_q == IW'(ID_BYTES - 1));

    // Lane index: restarts on clear, advances per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ID_BYTES - 1; g++) begin : g_lane
        logic [7:0] lane_q;

        // Lane register: holds the byte that arrived at this position.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (take && idx_q == IW'(g)) begin
                lane_q <= rx_data_i;
            end
        end

        assign full_o[g*8 +: 8] = lane_q;
    end

    assign full_o[8*ID_BYTES-1 -: 8] = rx_data_i;

endmodule

// File: rtl/cbs_hdr_writer.sv
// Header write path. Forwards each received byte into the local buffer
// at a running byte index, and flags the end of a chunk and of the whole
// header. The running index doubles as the address of the next read.
// Assumes HDR_BYTES and CHUNK_BYTES are powers of two, CHUNK <= HDR.
module cbs_hdr_writer #(
    parameter int HDR_BYTES   = 4096,
    parameter int CHUNK_BYTES = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         en_i,
    input  logic                         chunked_i,
    input  logic                         rx_valid_i,
    input  logic [7:0]                   rx_data_i,
    output logic                         we_o,
    output logic [$clog2(HDR_BYTES)-1:0] waddr_o,
    output logic [7:0]                   wdata_o,
    output logic [31:0]                  next_addr_o,
    output logic                         chunk_end_o,
    output logic                         last_o
);

    localparam int AW = $clog2(HDR_BYTES);
    localparam int CW = $clog2(CHUNK_BYTES);

    logic [AW:0] idx_q;

    // Byte index: cleared at start of a run, advanced per written byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q <= '0;
        end else if (we_o) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign we_o        = en_i && rx_valid_i;
    assign waddr_o     = idx_q[AW-1:0];
    assign wdata_o     = rx_data_i;
    assign next_addr_o = 32'(idx_q);
    assign last_o      = we_o && (idx_q == (AW+1)'(HDR_BYTES - 1));
    assign chunk_end_o = chunked_i ? (we_o && idx_q[CW-1:0] == CW'(CHUNK_BYTES - 1))
                                   : last_o;

endmodule

// File: rtl/cart_boot_seq.sv
// Cartridge bring-up sequencer (top). On an idle start it releases the
// cartridge reset, waits BOOT_WAIT_CYC, polls the chip identifier until
// nonzero (each poll bounded by POLL_TIMEOUT_CYC, at most MAX_POLLS
// attempts), waits SETTLE_CYC and fetches the header into the buffer
// either in one read or in CHUNK_BYTES pieces. Assumes the bus side
// returns exactly the requested number of bytes for each header read.
module cart_boot_seq
    import cbs_pkg::*;
#(
    parameter int BOOT_WAIT_CYC    = 7_500_000,
    parameter int SETTLE_CYC       = 50_000,
    parameter int POLL_TIMEOUT_CYC = 4096,
    parameter int MAX_POLLS        = 64,
    parameter int HDR_BYTES        = 4096,
    parameter int CHUNK_BYTES      = 512,
    parameter int ID_BYTES         = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         ext_type_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         error_o,
    output logic                         cart_rst_n_o,
    output logic                         cmd_valid_o,
    input  logic                         cmd_ready_i,
    output logic [63:0]                  cmd_bytes_o,
    output logic [$clog2(HDR_BYTES):0]   cmd_len_o,
    input  logic                         rx_valid_i,
    input  logic [7:0]                   rx_data_i,
    output logic                         hdr_we_o,
    output logic [$clog2(HDR_BYTES)-1:0] hdr_addr_o,
    output logic [7:0]                   hdr_data_o,
    output logic [8*ID_BYTES-1:0]        chip_id_o
);

    localparam int HDR_AW  = $clog2(HDR_BYTES);
    localparam int LEN_W   = HDR_AW + 1;
    localparam int ID_W    = 8 * ID_BYTES;
    localparam int PCNT_W  = $clog2(MAX_POLLS + 1);
    localparam int TMR_MAX =
        (BOOT_WAIT_CYC > SETTLE_CYC)
            ? ((BOOT_WAIT_CYC > POLL_TIMEOUT_CYC) ? BOOT_WAIT_CYC : POLL_TIMEOUT_CYC)
            : ((SETTLE_CYC > POLL_TIMEOUT_CYC) ? SETTLE_CYC : POLL_TIMEOUT_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    seq_state_t        state_q;
    logic              ext_q;
    logic [PCNT_W-1:0] polls_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              id_last;
    logic [ID_W-1:0]   id_full;
    logic              id_good;
    logic              poll_fail;
    logic              chunked;
    logic [31:0]       next_addr;
    logic              chunk_end;
    logic              hdr_last;
    cmd_kind_t         cmd_kind;

    assign busy_o      = (state_q != ST_IDLE);
    assign cmd_valid_o = (state_q == ST_ID_CMD) || (state_q == ST_HDR_CMD);
    assign cmd_kind    = (state_q == ST_HDR_CMD) ? CMD_HDR : CMD_ID;
    assign chunked     = ext_q && chip_id_o[ID_W-1];
    assign id_good     = id_last && (id_full != '0);
    assign poll_fail   = (state_q == ST_ID_RX) &&
                         ((id_last && id_full == '0) || (!id_last && tmr_zero));

    cbs_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    cbs_id_capture #(.ID_BYTES(ID_BYTES)) u_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (state_q != ST_ID_RX),
        .en_i       (state_q == ST_ID_RX),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .last_o     (id_last),
        .full_o     (id_full)
    );

    cbs_hdr_writer #(.HDR_BYTES(HDR_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_hdr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (state_q == ST_IDLE),
        .en_i        (state_q == ST_HDR_RX),
        .chunked_i   (chunked),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .we_o        (hdr_we_o),
        .waddr_o     (hdr_addr_o),
        .wdata_o     (hdr_data_o),
        .next_addr_o (next_addr),
        .chunk_end_o (chunk_end),
        .last_o      (hdr_last)
    );

    cbs_cmd_fmt #(
        .ID_BYTES    (ID_BYTES),
        .HDR_BYTES   (HDR_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES),
        .LEN_W       (LEN_W)
    ) u_fmt (
        .kind_i    (cmd_kind),
        .chunked_i (chunked),
        .addr_i    (next_addr),
        .bytes_o   (cmd_bytes_o),
        .len_o     (cmd_len_o)
    );

    // Timer reload: boot wait on start, poll window on ID command, settle on good ID.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(BOOT_WAIT_CYC - 1);
                end
            end
            ST_ID_CMD: begin
                if (cmd_ready_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(POLL_TIMEOUT_CYC - 1);
                end
            end
            ST_ID_RX: begin
                if (id_good) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_CYC - 1);
                end
            end
            default: ;
        endcase
    end

    // Sequence control: state, flags, attempt count and captured ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ext_q        <= 1'b0;
            polls_q      <= '0;
            done_o       <= 1'b0;
            error_o      <= 1'b0;
            cart_rst_n_o <= 1'b0;
            chip_id_o    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q      <= ST_BOOT;
                        ext_q        <= ext_type_i;
                        polls_q      <= '0;
                        done_o       <= 1'b0;
                        error_o      <= 1'b0;
                        cart_rst_n_o <= 1'b1;
                        chip_id_o    <= '0;
                    end
                end
                ST_BOOT: begin
                    if (tmr_zero) state_q <= ST_ID_CMD;
                end
                ST_ID_CMD: begin
                    if (cmd_ready_i) state_q <= ST_ID_RX;
                end
                ST_ID_RX: begin
                    if (id_good) begin
                        chip_id_o <= id_full;
                        state_q   <= ST_SETTLE;
                    end else if (poll_fail) begin
                        if (polls_q == PCNT_W'(MAX_POLLS - 1)) begin
                            error_o      <= 1'b1;
                            cart_rst_n_o <= 1'b0;
                            state_q      <= ST_IDLE;
                        end else begin
                            polls_q <= polls_q + 1'b1;
                            state_q <= ST_ID_CMD;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_zero) state_q <= ST_HDR_CMD;
                end
                ST_HDR_CMD: begin
                    if (cmd_ready_i) state_q <= ST_HDR_RX;
                end
                ST_HDR_RX: begin
                    if (hdr_last) begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (chunk_end) begin
                        state_q <= ST_HDR_CMD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cart_boot_seq_chk.sv
// Protocol checker for the bring-up sequencer, bound to every instance.
// Observes ports only; holds no state of its own.
module cart_boot_seq_chk #(
    parameter int HDR_BYTES   = 4096,
    parameter int CHUNK_BYTES = 512,
    parameter int HDR_AW      = 12,
    parameter int LEN_W       = 13,
    parameter int ID_W        = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o,
    input logic              cart_rst_n_o,
    input logic              cmd_valid_o,
    input logic              cmd_ready_i,
    input logic [63:0]       cmd_bytes_o,
    input logic [LEN_W-1:0]  cmd_len_o,
    input logic              hdr_we_o,
    input logic [HDR_AW-1:0] hdr_addr_o,
    input logic [ID_W-1:0]   chip_id_o
);

    assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=>
            cmd_valid_o && $stable(cmd_bytes_o) && $stable(cmd_len_o));

    assert_id_cmd_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_bytes_o[63:56] == 8'h90 |->
            cmd_bytes_o[55:0] == 56'h0 && cmd_len_o == LEN_W'(4));

    assert_hdr_cmd_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_bytes_o[63:56] == 8'h00 |->
            cmd_bytes_o[23:0] == 24'h0 &&
            (cmd_len_o == LEN_W'(CHUNK_BYTES) || cmd_len_o == LEN_W'(HDR_BYTES)));

    assert_no_cmd_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cart_rst_n_o |-> !cmd_valid_o);

    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(hdr_we_o) && $past(hdr_addr_o) == HDR_AW'(HDR_BYTES - 1));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !error_o);

    assert_error_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> !cart_rst_n_o && !busy_o);

    assert_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we_o |-> busy_o);

    assert_done_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> chip_id_o != '0);

endmodule

bind cart_boot_seq cart_boot_seq_chk #(
    .HDR_BYTES   (HDR_BYTES),
    .CHUNK_BYTES (CHUNK_BYTES),
    .HDR_AW      (HDR_AW),
    .LEN_W       (LEN_W),
    .ID_W        (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .cart_rst_n_o (cart_rst_n_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_bytes_o  (cmd_bytes_o),
    .cmd_len_o    (cmd_len_o),
    .hdr_we_o     (hdr_we_o),
    .hdr_addr_o   (hdr_addr_o),
    .chip_id_o    (chip_id_o)
);

// File: tb/cart_boot_seq_tb.sv
module cart_boot_seq_tb;

    localparam int BOOT = 40;
    localparam int SETTLE = 15;
    localparam int PTO = 30;
    localparam int MAXP = 4;
    localparam int HB = 4096;
    localparam int CB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ext = 1'b0;
    logic        busy, done, error, cart_rst_n, cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [63:0] cmd_bytes;
    logic [12:0] cmd_len;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        hdr_we;
    logic [11:0] hdr_addr;
    logic [7:0]  hdr_data;
    logic [31:0] chip_id;

    cart_boot_seq #(
        .BOOT_WAIT_CYC(BOOT), .SETTLE_CYC(SETTLE), .POLL_TIMEOUT_CYC(PTO),
        .MAX_POLLS(MAXP), .HDR_BYTES(HB), .CHUNK_BYTES(CB), .ID_BYTES(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ext_type_i(ext),
        .busy_o(busy), .done_o(done), .error_o(error), .cart_rst_n_o(cart_rst_n),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_bytes_o(cmd_bytes),
        .cmd_len_o(cmd_len), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .hdr_we_o(hdr_we), .hdr_addr_o(hdr_addr), .hdr_data_o(hdr_data),
        .chip_id_o(chip_id)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    int total = 0;
    int bad = 0;

    // cartridge model state
    logic        silent_q [8];
    logic [31:0] reply_q [8];
    logic [63:0] log_b [16];
    int          log_len [16];
    int          log_cyc [16];
    int          ncmd, poll_n, last_id_cyc, stable_bad, wr_cnt, hdr_bad, start_cyc;
    logic [7:0]  salt;
    logic [63:0] m_b;
    int          m_l, m_p, m_idx;
    logic [31:0] m_a;

    function automatic logic [7:0] hbyte(input logic [31:0] a, input logic [7:0] s);
        return a[7:0] ^ {a[3:0], a[11:8]} ^ s;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cartridge model: accepts commands, answers ID polls and header reads.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                m_b = cmd_bytes;
                m_l = int'(cmd_len);
                m_idx = (ncmd < 16) ? ncmd : 15;
                log_b[m_idx] = m_b;
                log_len[m_idx] = m_l;
                log_cyc[m_idx] = cyc;
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    if (!cmd_valid || cmd_bytes !== m_b || int'(cmd_len) != m_l) stable_bad++;
                end
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                ncmd++;
                if (m_b[63:56] == 8'h90) begin
                    m_p = poll_n % 8;
                    poll_n++;
                    if (!silent_q[m_p]) begin
                        for (int k = 0; k < 4; k++) begin
                            repeat ($urandom_range(0, 2)) @(negedge clk);
                            rx_valid = 1'b1;
                            rx_data = reply_q[m_p][8*k +: 8];
                            if (k == 3) last_id_cyc = cyc + 1;
                            @(negedge clk);
                            rx_valid = 1'b0;
                        end
                    end
                end else begin
                    m_a = m_b[55:24];
                    for (int i = 0; i < m_l; i++) begin
                        if ($urandom_range(0, 7) == 0) @(negedge clk);
                        rx_valid = 1'b1;
                        rx_data = hbyte(m_a + 32'(i), salt);
                        @(negedge clk);
                        rx_valid = 1'b0;
                    end
                end
            end
        end
    end

    // Buffer monitor: sampled mid-phase, away from both clock edges.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (hdr_we) begin
                if (int'(hdr_addr) != wr_cnt || hdr_data !== hbyte({20'h0, hdr_addr}, salt))
                    hdr_bad++;
                wr_cnt++;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run_seq(input bit e, input int nfail, input logic [7:0] smask,
                           input logic [31:0] id, input bit poke);
        bit err, chunked, poked;
        int polls, nh, w, nid;
        err = (nfail >= MAXP);
        chunked = e && id[31];
        polls = err ? MAXP : nfail + 1;
        nh = err ? 0 : (chunked ? 8 : 1);
        for (int p = 0; p < 8; p++) begin
            silent_q[p] = (p < nfail) ? smask[p] : 1'b0;
            reply_q[p] = (p < nfail) ? 32'h0 : id;
        end
        ncmd = 0; poll_n = 0; stable_bad = 0; wr_cnt = 0; hdr_bad = 0;
        last_id_cyc = 0; poked = 1'b0;
        salt = 8'($urandom);
        ext = e;
        start = 1'b1;
        start_cyc = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        ext = ~e;
        chk(done == 1'b0 && busy == 1'b1, "R11", "start clears done, sets busy",
            {done, busy}, 2'b01);
        chk(cart_rst_n == 1'b1, "R2", "cartridge reset released", cart_rst_n, 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!(done || error) && w < 20000) begin
            @(negedge clk);
            w++;
            if (poke && !poked && wr_cnt >= 1000) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                poked = 1'b1;
            end
        end
        chk(w < 20000, "R11", "sequence finished", w, 0);
        repeat (3) @(negedge clk);
        nid = 0;
        for (int c = 0; c < ncmd && c < 16; c++)
            if (log_b[c][63:56] == 8'h90) begin
                nid++;
                chk(log_b[c] == {8'h90, 56'h0} && log_len[c] == 4, "R3", "ID command form",
                    log_b[c], {8'h90, 56'h0});
            end
        chk(nid == polls, "R5", "ID attempts (R4 retries)", nid, polls);
        chk(ncmd == polls + nh, "R9", "total command count", ncmd, polls + nh);
        chk(log_cyc[0] - start_cyc == BOOT, poke ? "R12" : "R2", "boot wait cycles",
            log_cyc[0] - start_cyc, BOOT);
        if (!err) begin
            chk(log_cyc[polls] - last_id_cyc == SETTLE, "R7", "settle cycles",
                log_cyc[polls] - last_id_cyc, SETTLE);
            for (int h = 0; h < nh; h++) begin
                chk(log_b[polls + h] == {8'h00, 32'(h * CB), 24'h0}, "R8", "header command",
                    log_b[polls + h], {8'h00, 32'(h * CB), 24'h0});
                chk(log_len[polls + h] == (chunked ? CB : HB), "R9", "header length",
                    log_len[polls + h], chunked ? CB : HB);
            end
        end
        chk(wr_cnt == (err ? 0 : HB), poke ? "R12" : "R10", "bytes written",
            wr_cnt, err ? 0 : HB);
        chk(hdr_bad == 0, "R10", "buffer address/data mismatches", hdr_bad, 0);
        chk(chip_id == (err ? 32'h0 : id), "R4", "captured chip ID", chip_id, err ? 0 : id);
        chk(done == !err && busy == 1'b0, "R11", "done level after run", done, !err);
        chk(error == err && cart_rst_n == !err, "R6", "error flag and cartridge reset",
            {error, cart_rst_n}, {err, !err});
        chk(stable_bad == 0, "R13", "command held until ready", stable_bad, 0);
        repeat (5) @(negedge clk);
        chk(done == !err, "R11", "done persists", done, !err);
    endtask

    initial begin
        logic [31:0] rid;
        void'($urandom(32'h5EED_0C0D));
        repeat (5) @(negedge clk);
        chk(cart_rst_n == 0 && busy == 0 && done == 0 && error == 0 && cmd_valid == 0
            && hdr_we == 0 && chip_id == 0, "R1", "reset state",
            {cart_rst_n, busy, done, error, cmd_valid, hdr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cart_rst_n == 0 && busy == 0 && cmd_valid == 0, "R1", "idle after reset",
            {cart_rst_n, busy, cmd_valid}, 0);
        // flag clear but ID bit31 set: single read; one zero reply
        run_seq(1'b0, 1, 8'h00, 32'h8000_00C2, 1'b0);
        // chunked; one silent attempt then one zero; start pokes while busy
        run_seq(1'b1, 2, 8'h01, 32'h9ABC_0001, 1'b1);
        // flag set but bit31 clear: single read
        run_seq(1'b1, 0, 8'h00, 32'h1234_5678, 1'b0);
        // boundary: MAX_POLLS-1 failures still succeed
        run_seq(1'b1, MAXP - 1, 8'h05, 32'hC000_0100, 1'b0);
        // MAX_POLLS failures: error
        run_seq(1'b0, MAXP, 8'h0A, 32'h0000_0055, 1'b0);
        // recovery after error
        run_seq(1'b0, 0, 8'h00, 32'h0000_0001, 1'b0);
        for (int r = 0; r < 3; r++) begin
            rid = $urandom;
            if (rid == 0) rid = 32'h1;
            run_seq(1'($urandom_range(0, 1)), $urandom_range(0, MAXP - 1),
                    8'($urandom), rid, 1'b0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule